// File: doc/BRIEF.md
# Serial Flash Page-Program Engine

This block is the device-side command logic of a serial NOR flash. It listens on a four-wire serial port in mode 0: data is captured on the rising edge of the serial clock and driven out on the falling edge. All port pins are sampled by a faster system clock. The block decodes a small command set. A write-enable command arms the write latch. A status read returns the flags. A page-program command carries a 24-bit address and a stream of data bytes. A data read returns array contents so that programmed values can be seen.

During a program command the data bytes go into a 256-byte page buffer. The byte pointer wraps inside the page, so when more than a page is sent only the most recent bytes are kept. The buffered page is committed only under three conditions: chip select rises exactly on a byte boundary after at least one complete data byte, the latch was armed, and the target page is outside the protected region. Protection is set by a strapped 3-bit level. A commit starts a self-timed program cycle. During that cycle each buffered byte is ANDed into the array, because programming can only clear bits. The array is a small RAM that comes out of reset fully erased (0xFF), and the pages alias across the 24-bit address space.

Top module: `spi_pp_engine`

## Requirements
- R1: After reset the status byte reads 0x00 apart from the protect level in bits 4:2, and every array byte reads 0xFF.
- R2: Opcode 0x06, when the device is idle, sets the write latch, which reads back as status bit 1.
- R3: Opcode 0x02 with the write latch clear changes no array byte and starts no program cycle.
- R4: A programmed array byte becomes its previous value ANDed with the data byte sent.
- R5: Within a program command the byte pointer steps through the low 8 address bits and wraps from 0xFF to 0x00 inside the same page.
- R6: When more than 256 data bytes are sent, each page location holds the last byte sent to it.
- R7: Page locations that received no data byte in the command keep their previous contents.
- R8: If chip select rises anywhere other than right after bit 8 of a data byte, or before the first data byte is complete, nothing is programmed and the write latch stays set.
- R9: A valid commit makes status bit 0 read 1 and clears the write latch at once. Bit 0 returns to 0 when the cycle of max(PROG_CYCLES,256) system clocks ends.
- R10: With protect level n (1 to 7), an address whose bits 19:(12+n) are all ones is protected. A program command aimed there changes nothing and leaves the latch set. Level 0 protects nothing.
- R11: Address bits 23:20 are ignored. The array is PAGES pages of 256 bytes, addressed by address bits 8+log2(PAGES)-1:0, and it aliases above that.
- R12: While a program cycle runs, every opcode except 0x05 is ignored; in particular 0x06 does not set the latch.
- R13: Opcode 0x03 followed by a 24-bit address returns array bytes MSB first from that address on, incrementing and wrapping at the array size.
- R14: Opcode 0x05 returns the status byte {000, level, latch, busy}, repeated for as long as clocking continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the device |
| prot_level | input | 3 | Strapped block-protect level, shown in status bits 4:2 |
| miso | output | 1 | Serial data out of the device |

## Verification
The assertions assume that the serial clock runs slowly against the system clock, with each phase lasting at least four system clocks. They also assume that mosi changes only while sck is low, and that prot_level holds steady from the start of a command until its program cycle has started. The stimulus meets these conditions. It holds each sck phase for exactly four clocks, drives mosi in the same step that lowers sck, and changes the protect level only between frames, while chip select is high.

// File: rtl/spf_pkg.sv
// Shared opcodes, command phases and the protection decode for the
// page-program engine. Assumes a 20-bit meaningful address space.
package spf_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_READ = 8'h03;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_PDATA,
        PH_RDATA,
        PH_STAT,
        PH_DROP
    } phase_t;

    // Level n guards the region where address bits 19:(12+n) are all ones.
    function automatic logic prot_hit(input logic [2:0] lvl, input logic [7:0] top);
        logic [7:0] low_mask;
        low_mask = 8'hFF >> (4'd8 - {1'b0, lvl});
        return (lvl != 3'd0) && ((top | low_mask) == 8'hFF);
    endfunction

endpackage

// File: rtl/spi_link.sv
// Serial front end: synchronises the pins into clk, assembles bytes on
// sck rising edges and shifts the transmit byte out on falling edges.
// Assumes each sck phase lasts at least four clk periods.
module spi_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       byte_stb,
    output logic       cs_end,
    output logic       at_bound,
    output logic       miso
);

    logic [2:0] cs_s;
    logic [2:0] sck_s;
    logic [1:0] mo_s;
    logic       cs_act;
    logic       sck_rise;
    logic       sck_fall;
    logic [2:0] bit_cnt;
    logic [6:0] sh_q;
    logic [7:0] tx_q;

    // Two-stage synchronisers plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_s  <= 3'b111;
            sck_s <= 3'b000;
            mo_s  <= 2'b00;
        end else begin
            cs_s  <= {cs_s[1:0], cs_n};
            sck_s <= {sck_s[1:0], sck};
            mo_s  <= {mo_s[0], mosi};
        end
    end

    assign cs_act   = !cs_s[1];
    assign cs_end   = cs_s[1] && !cs_s[2];
    assign sck_rise = cs_act && sck_s[1] && !sck_s[2];
    assign sck_fall = cs_act && !sck_s[1] && sck_s[2];

    // Bit counter and receive shifter, cleared whenever the device is deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            bit_cnt <= 3'd0;
            sh_q    <= 7'd0;
        end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            sh_q    <= {sh_q[5:0], mo_s[1]};
        end
    end

    assign rx_byte  = {sh_q, mo_s[1]};
    assign byte_stb = sck_rise && (bit_cnt == 3'd7);
    assign at_bound = (bit_cnt == 3'd0);

    // Transmit shifter: the first falling edge of a byte keeps the MSB on the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= 8'hFF;
        end else if (tx_load) begin
            tx_q <= tx_byte;
        end else if (sck_fall && (bit_cnt != 3'd0)) begin
            tx_q <= {tx_q[6:0], 1'b1};
        end
    end

    assign miso = tx_q[7];

    AST_BITCNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (bit_cnt == 3'd0)); // R8

endmodule

// File: rtl/page_store.sv
// Page buffer: one byte and one valid flag per page location. Later
// writes to a location replace earlier ones; clr drops all valid flags.
// Assumes the caller wraps the index inside the page.
module page_store #(
    parameter int PAGE_BYTES = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          wr_en,
    input  logic [$clog2(PAGE_BYTES)-1:0] wr_idx,
    input  logic [7:0]                    wr_data,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
    output logic [7:0]                    rd_data,
    output logic                          rd_vld
);

    logic [7:0]            pg_mem [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    // Data storage, no reset needed because valid flags qualify every read.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            pg_mem[wr_idx] <= wr_data;
        end
    end

    // Valid flags: cleared at the start of each program command.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    assign rd_data = pg_mem[rd_idx];
    assign rd_vld  = vld_q[rd_idx];

endmodule

// File: rtl/cell_array.sv
// Storage array model: reset erases every byte to 0xFF and a write can
// only clear bits. There is one write port and one registered read port.
module cell_array #(
    parameter int PAGES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [$clog2(PAGES*256)-1:0]      waddr,
    input  logic [7:0]                        wdata,
    input  logic [$clog2(PAGES*256)-1:0]      raddr,
    output logic [7:0]                        rdata
);

    localparam int DEPTH = PAGES * 256;

    logic [7:0] cells [DEPTH];

    // Erase on reset, otherwise AND the new data into the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= 8'hFF;
            end
        end else if (we) begin
            cells[waddr] <= cells[waddr] & wdata;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 8'hFF;
        end else begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/spi_pp_engine.sv
// Top of the page-program engine: command decode, address capture, page
// buffering, commit qualification and the self-timed program sequencer.
// Assumes PAGES is a power of two from 2 to 256 and that prot_level is
// steady during a command.
module spi_pp_engine #(
    parameter int PAGES       = 4,
    parameter int PROG_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic [2:0] prot_level,
    output logic       miso
);

    import spf_pkg::*;

    localparam int PG_AW = $clog2(PAGES);
    localparam int AW    = PG_AW + 8;
    localparam int TOTAL = (PROG_CYCLES > 256) ? PROG_CYCLES : 256;
    localparam int CW    = $clog2(TOTAL) + 1;

    logic [7:0]       rx_byte;
    logic             byte_stb;
    logic             cs_end;
    logic             at_bound;
    logic             tx_load;
    logic [7:0]       tx_byte;

    phase_t           phase;
    logic [1:0]       acnt;
    logic [19:0]      addr_q;
    logic             is_prog;
    logic             got_data;
    logic [7:0]       ptr;
    logic [AW-1:0]    rd_ptr;
    logic [1:0]       ld_pipe;

    logic             wel;
    logic             busy;
    logic [CW-1:0]    pcnt;
    logic [PG_AW-1:0] ppage;

    logic             opc_stb;
    logic             stat_ld;
    logic             pg_clr;
    logic             pg_wr;
    logic [7:0]       pg_data;
    logic             pg_vld;
    logic             commit;
    logic             arr_we;
    logic [7:0]       arr_q;
    logic [7:0]       status;

    spi_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .mosi     (mosi),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .rx_byte  (rx_byte),
        .byte_stb (byte_stb),
        .cs_end   (cs_end),
        .at_bound (at_bound),
        .miso     (miso)
    );

    assign opc_stb = byte_stb && (phase == PH_OPC);
    assign status  = {3'b000, prot_level, wel, busy};
    assign stat_ld = (opc_stb && (rx_byte == OP_RDSR)) || (byte_stb && (phase == PH_STAT));
    assign tx_load = stat_ld || ld_pipe[1];
    assign tx_byte = ld_pipe[1] ? arr_q : status;
    assign pg_clr  = opc_stb && (rx_byte == OP_PROG) && wel && !busy;
    assign pg_wr   = byte_stb && (phase == PH_PDATA);

    // Command phase tracking, address capture and read-out pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_OPC;
            acnt     <= 2'd0;
            addr_q   <= 20'd0;
            is_prog  <= 1'b0;
            got_data <= 1'b0;
            ptr      <= 8'd0;
            rd_ptr   <= '0;
            ld_pipe  <= 2'b00;
        end else begin
            ld_pipe <= {ld_pipe[0], 1'b0};
            if (ld_pipe[1]) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (cs_end) begin
                phase    <= PH_OPC;
                acnt     <= 2'd0;
                got_data <= 1'b0;
            end else if (byte_stb) begin
                case (phase)
                    PH_OPC: begin
                        if (rx_byte == OP_RDSR) begin
                            phase <= PH_STAT;
                        end else if (busy) begin
                            phase <= PH_DROP;
                        end else if ((rx_byte == OP_PROG) && wel) begin
                            phase   <= PH_ADDR;
                            is_prog <= 1'b1;
                        end else if (rx_byte == OP_READ) begin
                            phase   <= PH_ADDR;
                            is_prog <= 1'b0;
                        end else begin
                            phase <= PH_DROP;
                        end
                    end
                    PH_ADDR: begin
                        addr_q <= {addr_q[11:0], rx_byte};
                        acnt   <= acnt + 2'd1;
                        if (acnt == 2'd2) begin
                            if (is_prog) begin
                                phase <= PH_PDATA;
                                ptr   <= rx_byte;
                            end else begin
                                phase   <= PH_RDATA;
                                rd_ptr  <= {addr_q[PG_AW-1:0], rx_byte};
                                ld_pipe <= {ld_pipe[0], 1'b1};
                            end
                        end
                    end
                    PH_PDATA: begin
                        ptr      <= ptr + 8'd1;
                        got_data <= 1'b1;
                    end
                    PH_RDATA: begin
                        ld_pipe <= {ld_pipe[0], 1'b1};
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign commit = cs_end && (phase == PH_PDATA) && got_data && at_bound
                    && !prot_hit(prot_level, addr_q[19:12]);

    // Write latch and self-timed program cycle sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel   <= 1'b0;
            busy  <= 1'b0;
            pcnt  <= '0;
            ppage <= '0;
        end else if (commit) begin
            wel   <= 1'b0;
            busy  <= 1'b1;
            pcnt  <= '0;
            ppage <= addr_q[PG_AW+7:8];
        end else if (busy) begin
            pcnt <= pcnt + 1'b1;
            if (pcnt == CW'(TOTAL - 1)) begin
                busy <= 1'b0;
            end
        end else if (opc_stb && (rx_byte == OP_WREN)) begin
            wel <= 1'b1;
        end
    end

    page_store #(
        .PAGE_BYTES (256)
    ) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pg_clr),
        .wr_en   (pg_wr),
        .wr_idx  (ptr),
        .wr_data (rx_byte),
        .rd_idx  (pcnt[7:0]),
        .rd_data (pg_data),
        .rd_vld  (pg_vld)
    );

    assign arr_we = busy && (pcnt < CW'(256)) && pg_vld;

    cell_array #(
        .PAGES (PAGES)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr ({ppage, pcnt[7:0]}),
        .wdata (pg_data),
        .raddr (rd_ptr),
        .rdata (arr_q)
    );

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (pcnt != CW'(TOTAL - 1))) |=> busy); // R9

    AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !wel); // R9

    AST_PP_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel)); // R3

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !wel); // R12

    AST_NO_PROT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !prot_hit(prot_level, addr_q[19:12])); // R10

endmodule

// File: tb/sim_spi_pp_engine.sv
module sim_spi_pp_engine;

    localparam int PAGES = 4;
    localparam int PROGC = 600;
    localparam int DEPTH = PAGES * 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic [2:0] prot_level = 3'd0;
    logic       miso;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [7:0] model [DEPTH];
    logic       wel_m;

    always #4 clk = ~clk;

    spi_pp_engine #(.PAGES(PAGES), .PROG_CYCLES(PROGC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .prot_level(prot_level), .miso(miso)
    );

    typedef struct packed {
        logic       wren;
        logic [2:0] bp;
        logic [23:0] addr;
        logic [9:0] n;
        logic [2:0] extra;
        logic [7:0] seed;
        logic [23:0] ra;
        logic [9:0] rn;
        logic [3:0] tag;
    } vec_t;

    localparam vec_t TBL [11] = '{
        '{1'b0, 3'd0, 24'h000010, 10'd4,   3'd0, 8'h5A, 24'h00000C, 10'd12,  4'd3},  // R3
        '{1'b1, 3'd0, 24'h000010, 10'd4,   3'd0, 8'h3C, 24'h00000C, 10'd12,  4'd7},  // R7
        '{1'b1, 3'd0, 24'h000012, 10'd4,   3'd0, 8'hF0, 24'h00000C, 10'd12,  4'd4},  // R4
        '{1'b1, 3'd0, 24'h0001FC, 10'd8,   3'd0, 8'hA5, 24'h000100, 10'd256, 4'd5},  // R5
        '{1'b1, 3'd0, 24'h000200, 10'd300, 3'd0, 8'h11, 24'h000200, 10'd256, 4'd6},  // R6
        '{1'b1, 3'd0, 24'h000040, 10'd5,   3'd3, 8'h77, 24'h00003C, 10'd12,  4'd8},  // R8
        '{1'b0, 3'd0, 24'h000050, 10'd0,   3'd0, 8'h00, 24'h00004C, 10'd8,   4'd8},  // R8
        '{1'b0, 3'd7, 24'h080300, 10'd4,   3'd0, 8'h99, 24'h000300, 10'd8,   4'd10}, // R10
        '{1'b0, 3'd7, 24'hF00310, 10'd4,   3'd0, 8'hC3, 24'h000300, 10'd32,  4'd11}, // R11
        '{1'b1, 3'd1, 24'h0FE020, 10'd4,   3'd0, 8'hE7, 24'h000020, 10'd8,   4'd10}, // R10
        '{1'b0, 3'd1, 24'h0FC020, 10'd4,   3'd0, 8'h1B, 24'h000020, 10'd8,   4'd10}  // R10
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic desel();
        sck  = 1'b0;
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            tick(4);
            rx[b] = miso;
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] dummy;
        xfer(tx, dummy);
    endtask

    task automatic send_addr(input logic [23:0] a);
        send(a[23:16]);
        send(a[15:8]);
        send(a[7:0]);
    endtask

    task automatic wren();
        sel();
        send(8'h06);
        desel();
    endtask

    task automatic rd_status(output logic [7:0] s);
        sel();
        send(8'h05);
        xfer(8'h00, s);
        desel();
    endtask

    function automatic logic [7:0] dat(input logic [7:0] s, input int k);
        return s ^ 8'(k * 7) ^ 8'(k >> 2);
    endfunction

    function automatic bit guarded(input logic [2:0] lvl, input logic [23:0] a);
        if (lvl == 3'd0) return 1'b0;
        return (a[19:12] >> lvl) == (8'hFF >> lvl);
    endfunction

    task automatic prog(input logic [23:0] a, input int n, input logic [7:0] seed, input int extra);
        sel();
        send(8'h02);
        send_addr(a);
        for (int k = 0; k < n; k++) send(dat(seed, k));
        for (int e = 0; e < extra; e++) begin
            mosi = 1'b1;
            tick(4);
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
        end
        desel();
    endtask

    task automatic model_prog(input logic [23:0] a, input int n, input logic [7:0] seed);
        logic [7:0] pb [256];
        bit         pv [256];
        int         base;
        for (int i = 0; i < 256; i++) pv[i] = 1'b0;
        for (int k = 0; k < n; k++) begin
            pb[(a[7:0] + k) & 255] = dat(seed, k);
            pv[(a[7:0] + k) & 255] = 1'b1;
        end
        base = int'(a[9:8]) * 256;
        for (int i = 0; i < 256; i++) if (pv[i]) model[base + i] = model[base + i] & pb[i];
    endtask

    task automatic rd_check(input logic [23:0] ra, input int rn, input string tag);
        logic [7:0] b;
        sel();
        send(8'h03);
        send_addr(ra);
        for (int i = 0; i < rn; i++) begin
            xfer(8'h00, b);
            check(tag, b, model[(int'(ra[9:0]) + i) % DEPTH]);
        end
        desel();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 30; i++) begin
            rd_status(s);
            if (s[0] == 1'b0) break;
        end
    endtask

    task automatic model_erase();
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        wel_m = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, s2;
        bit         ok;
        model_erase();
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R1: reset state of status and array
        rd_status(s);
        check("R1", s, 8'h00);
        rd_check(24'h000000, 4, "R1");

        // R14: status repeats within one frame and carries the level
        prot_level = 3'd5;
        tick(2);
        sel();
        send(8'h05);
        xfer(8'h00, s);
        xfer(8'h00, s2);
        desel();
        check("R14", s, 8'h14);
        check("R14", s2, 8'h14);
        prot_level = 3'd0;
        tick(2);

        // Table walk: program, status right after, wait, read back
        for (int v = 0; v < 11; v++) begin
            prot_level = TBL[v].bp;
            tick(2);
            if (TBL[v].wren) begin
                wren();
                wel_m = 1'b1;
            end
            prog(TBL[v].addr, int'(TBL[v].n), TBL[v].seed, int'(TBL[v].extra));
            ok = wel_m && (TBL[v].extra == 3'd0) && (TBL[v].n != 10'd0)
                 && !guarded(TBL[v].bp, TBL[v].addr);
            rd_status(s);
            check($sformatf("R%0d status", TBL[v].tag), s,
                  {3'b000, TBL[v].bp, ok ? 1'b0 : wel_m, ok});
            wait_idle();
            if (ok) begin
                model_prog(TBL[v].addr, int'(TBL[v].n), TBL[v].seed);
                wel_m = 1'b0;
            end
            rd_status(s);
            check($sformatf("R%0d idle", TBL[v].tag), s, {3'b000, TBL[v].bp, wel_m, 1'b0});
            rd_check(TBL[v].ra, int'(TBL[v].rn), $sformatf("R%0d data", TBL[v].tag));
        end

        // R2: write enable sets the latch
        prot_level = 3'd0;
        tick(2);
        wren();
        rd_status(s);
        check("R2", s, 8'h02);

        // R12: during a cycle a write enable and a program are ignored
        prog(24'h000380, 2, 8'h0F, 0);
        model_prog(24'h000380, 2, 8'h0F);
        wren();
        prog(24'h000390, 2, 8'h00, 0);
        rd_status(s);
        check("R12 busy", s, 8'h01);
        wait_idle();
        rd_status(s);
        check("R12 after", s, 8'h00);
        rd_check(24'h000380, 20, "R12");

        // R9: a committed cycle stays busy, then clears
        wren();
        prog(24'h000120, 1, 8'h00, 0);
        model_prog(24'h000120, 1, 8'h00);
        rd_status(s);
        check("R9 wip", s, 8'h01);
        tick(PROGC);
        rd_status(s);
        check("R9 done", s, 8'h00);

        // R13: read aliases and wraps around the array
        rd_check(24'hA00400, 4, "R13");
        rd_check(24'h0003FE, 4, "R13");

        // R1: reset in mid-run erases the array and clears the latch
        wren();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        model_erase();
        rd_status(s);
        check("R1 rerun", s, 8'h00);
        rd_check(24'h000200, 4, "R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule